// File: doc/BRIEF.md
# Per-Area External Bus Cycle Sequencer

This block turns single read and write requests from an internal master into external bus cycles. The address space is cut into eight equal areas, chosen by the top three bits of a 24-bit address. Each area carries its own settings: a data bus width of 8 or 16 bits, a basic cycle of two or three states, and a count of automatic wait states from 0 to 7. The settings are written through a small configuration port. While a cycle runs, the block drives the address, the write data lanes, an active-low chip select for the addressed area, and active-low read and write strobes. It also samples an active-low external wait input. When the access completes it returns a one-cycle done pulse, and on reads it returns the read data with that pulse.

Each bus state lasts one clock. The sequencer moves through these named states: IDLE, T1 (address and chip select out), T2 (strobe on), TW (programmed waits), TX (waits requested on the pin) and T3 (final state of a three-state cycle). It has these transitions:
- IDLE→T1 when a request is accepted.
- T1→T2 always.
- T2→IDLE or T2→T1 to finish a two-state cycle.
- T2→TW when the area has programmed waits.
- T2→TX or T2→T3 on the wait sample when the area has no programmed waits.
- TW→TW while programmed waits remain.
- TW→TX or TW→T3 on the wait sample in the last programmed wait.
- TX→TX while the pin is held low.
- TX→T3 when the pin is released.
- T3→T1 to start the second byte of a split word.
- T3→IDLE at the end of the access.

Requests are taken only in IDLE. The settings of the addressed area are captured when a request is accepted.

Top module: `bus_cycle_seq`

## Requirements
- R1: Address bits 23:21 select the area. Bit n of `cs_n` goes low for area n, and stays low with no other bit low from the first state of the access through its last state.
- R2: `bus16_mode` is 1 when at least one area is set to 16 bits, and 0 when all eight areas are set to 8 bits.
- R3: An access to a two-state area lasts exactly 2 states. Its programmed wait count and `wait_n` have no effect on it.
- R4: An access to a three-state area with programmed count n lasts 3+n states when `wait_n` stays high.
- R5: In a three-state area, `wait_n` is sampled at the end of the last programmed wait state, or at the end of the second state when n is 0. Each low sample adds one more state, and sampling continues in each added state. A low level on `wait_n` at any other time has no effect.
- R6: `rd_n` (reads) or `wr_n` (writes) is low from the second state of each byte or word cycle through its last state. Both strobes are high in the first state, and they never go low together.
- R7: In a 16-bit area, a byte access at an even address uses the upper lane [15:8], and one at an odd address uses the lower lane [7:0]. A word access uses both lanes, with the even byte on the upper lane and address bit 0 driven as 0. `bus_dout_en` bit 1 enables the upper lane and bit 0 the lower lane. Only the used lanes are enabled, and an undriven lane reads 0.
- R8: An 8-bit area uses only the upper lane. A word access to it runs as two back-to-back byte cycles: the even address first (data bits 15:8), then the odd address (bits 7:0). Only one done pulse is issued, after the second cycle.
- R9: `done` pulses for one clock in the cycle after the last state. On a read, `rdata` is valid in that cycle. A byte read returns its byte in bits 7:0 with bits 15:8 at 0.
- R10: After reset, every area is set to 8 bits, three states and 7 programmed waits. All chip selects and strobes are high, and `done` is low.
- R11: A configuration write (`cfg_we` high) loads the width, cycle type and wait count of area `cfg_area`. An access in progress keeps the settings captured when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one bus state per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_area | input | 3 | Area written by the configuration port |
| cfg_wide | input | 1 | 1 = 16-bit area, 0 = 8-bit area |
| cfg_three | input | 1 | 1 = three-state cycle, 0 = two-state cycle |
| cfg_waits | input | 3 | Programmed wait count |
| req_valid | input | 1 | Access request, taken in IDLE |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = word access, 0 = byte access |
| req_addr | input | 24 | Access address |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| done | output | 1 | Access complete pulse |
| rdata | output | 16 | Read data, valid with done |
| bus_addr | output | 24 | External address |
| bus_dout | output | 16 | External write data |
| bus_dout_en | output | 2 | Lane drive enables (bit 1 upper, bit 0 lower) |
| bus_din | input | 16 | External read data |
| cs_n | output | 8 | Per-area chip selects, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| wait_n | input | 1 | External wait request, active low |
| bus16_mode | output | 1 | Global bus mode, 1 = 16-bit |

## Verification
The bench times accesses by counting chip-select states. It holds `wait_n` low in set windows. A window placed on the sample point catches a sequencer that samples a state early or late, or that lets the pin stretch a two-state area. A window placed only before the sample point catches a design that reacts to the pin outside the sample point. The external data model puts a different byte on each address and lane. A wrong lane choice, a swapped byte order in a split word, or a byte read returned in the upper half therefore all show up as wrong data. A second done pulse from a split word is also counted. A configuration write in the middle of an access catches a sequencer that reads the live settings instead of the captured ones, because the access length would change.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int WAIT_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_T1,
        ST_T2,
        ST_TW,
        ST_TX,
        ST_T3
    } bus_state_e;

    typedef struct packed {
        logic              wide;
        logic              three;
        logic [WAIT_W-1:0] waits;
    } area_cfg_t;

endpackage

// File: rtl/bcs_cfg_bank.sv
module bcs_cfg_bank
    import bcs_pkg::*;
#(
    parameter int AREAS     = 8,
    parameter int RST_WAITS = 7,
    localparam int AREA_BITS = $clog2(AREAS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [AREA_BITS-1:0]      cfg_area,
    input  logic                      cfg_wide,
    input  logic                      cfg_three,
    input  logic [WAIT_W-1:0]         cfg_waits,
    output area_cfg_t [AREAS-1:0]     cfg_tbl,
    output logic                      mode16
);

    localparam area_cfg_t RST_CFG = '{wide: 1'b0, three: 1'b1, waits: WAIT_W'(RST_WAITS)};

    for (genvar g = 0; g < AREAS; g++) begin : g_area
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg_tbl[g] <= RST_CFG;
            end else if (cfg_we && (cfg_area == AREA_BITS'(g))) begin
                cfg_tbl[g] <= '{wide: cfg_wide, three: cfg_three, waits: cfg_waits};
            end
        end
    end

    // Global bus mode: any 16-bit area puts the bus in 16-bit mode.
    always_comb begin
        mode16 = 1'b0;
        for (int i = 0; i < AREAS; i++) begin
            mode16 = mode16 | cfg_tbl[i].wide;
        end
    end

endmodule

// File: rtl/bcs_seq_fsm.sv
module bcs_seq_fsm
    import bcs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       req_wide,
    input  area_cfg_t  sel_cfg,
    input  logic       wait_n,
    output area_cfg_t  cur_cfg,
    output logic       accept,
    output logic       active,
    output logic       strobe_on,
    output logic       last,
    output logic       final_last,
    output logic       split,
    output logic       second
);

    bus_state_e        state_q, state_d;
    logic [WAIT_W-1:0] wcnt_q, wcnt_d;
    area_cfg_t         cfg_q, cfg_d;
    logic              split_q, split_d;
    logic              second_q, second_d;
    bus_state_e        finish_st;

    // Where a completed byte or word cycle goes next.
    always_comb begin
        finish_st = (split_q && !second_q) ? ST_T1 : ST_IDLE;
    end

    always_comb begin
        state_d  = state_q;
        wcnt_d   = wcnt_q;
        cfg_d    = cfg_q;
        split_d  = split_q;
        second_d = second_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cfg_d    = sel_cfg;
                    split_d  = req_wide && !sel_cfg.wide;
                    second_d = 1'b0;
                    state_d  = ST_T1;
                end
            end
            ST_T1: begin
                state_d = ST_T2;
            end
            ST_T2: begin
                if (!cfg_q.three) begin
                    state_d = finish_st;
                    if (finish_st == ST_T1) second_d = 1'b1;
                end else if (cfg_q.waits != '0) begin
                    wcnt_d  = cfg_q.waits;
                    state_d = ST_TW;
                end else begin
                    state_d = wait_n ? ST_T3 : ST_TX;
                end
            end
            ST_TW: begin
                if (wcnt_q == WAIT_W'(1)) begin
                    state_d = wait_n ? ST_T3 : ST_TX;
                end else begin
                    wcnt_d = wcnt_q - WAIT_W'(1);
                end
            end
            ST_TX: begin
                if (wait_n) state_d = ST_T3;
            end
            ST_T3: begin
                state_d = finish_st;
                if (finish_st == ST_T1) second_d = 1'b1;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            wcnt_q   <= '0;
            cfg_q    <= '0;
            split_q  <= 1'b0;
            second_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            wcnt_q   <= wcnt_d;
            cfg_q    <= cfg_d;
            split_q  <= split_d;
            second_q <= second_d;
        end
    end

    always_comb begin
        accept     = (state_q == ST_IDLE) && req_valid;
        active     = (state_q != ST_IDLE);
        strobe_on  = active && (state_q != ST_T1);
        last       = ((state_q == ST_T2) && !cfg_q.three) || (state_q == ST_T3);
        final_last = last && !(split_q && !second_q);
        cur_cfg    = cfg_q;
        split      = split_q;
        second     = second_q;
    end

endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath #(
    parameter int AREAS  = 8,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    localparam int AREA_BITS = $clog2(AREAS),
    localparam int LANE_W    = DATA_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              req_write,
    input  logic              req_wide,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              area_wide,
    input  logic              active,
    input  logic              strobe_on,
    input  logic              last,
    input  logic              final_last,
    input  logic              split,
    input  logic              second,
    input  logic [DATA_W-1:0] bus_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic [1:0]        bus_dout_en,
    output logic [AREAS-1:0]  cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);

    logic [ADDR_W-1:0]    addr_q;
    logic [DATA_W-1:0]    wdata_q;
    logic                 write_q;
    logic                 wide_q;
    logic [LANE_W-1:0]    rbuf_q;
    logic                 done_q;
    logic [DATA_W-1:0]    rdata_q;
    logic [AREA_BITS-1:0] area_idx;
    logic [LANE_W-1:0]    rd_lane;
    logic                 use_low;

    always_comb begin
        area_idx = addr_q[ADDR_W-1 -: AREA_BITS];
        use_low  = area_wide && !wide_q && addr_q[0];
        rd_lane  = use_low ? bus_din[LANE_W-1:0] : bus_din[DATA_W-1:LANE_W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
            wide_q  <= 1'b0;
            rbuf_q  <= '0;
            done_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                write_q <= req_write;
                wide_q  <= req_wide;
            end
            if (last && !write_q && split && !second) begin
                rbuf_q <= rd_lane;
            end
            if (final_last) begin
                done_q <= 1'b1;
                if (!write_q) begin
                    if (split)       rdata_q <= {rbuf_q, rd_lane};
                    else if (wide_q) rdata_q <= bus_din;
                    else             rdata_q <= {{LANE_W{1'b0}}, rd_lane};
                end
            end
        end
    end

    // Bus outputs
    always_comb begin
        bus_addr    = '0;
        bus_dout    = '0;
        bus_dout_en = 2'b00;
        rd_n        = 1'b1;
        wr_n        = 1'b1;
        for (int i = 0; i < AREAS; i++) begin
            cs_n[i] = !(active && (area_idx == AREA_BITS'(i)));
        end
        if (active) begin
            if (split) begin
                bus_addr = {addr_q[ADDR_W-1:1], second};
            end else if (wide_q && area_wide) begin
                bus_addr = {addr_q[ADDR_W-1:1], 1'b0};
            end else begin
                bus_addr = addr_q;
            end
            rd_n = !(strobe_on && !write_q);
            wr_n = !(strobe_on && write_q);
            if (write_q) begin
                if (split) begin
                    bus_dout[DATA_W-1:LANE_W] = second ? wdata_q[LANE_W-1:0]
                                                       : wdata_q[DATA_W-1:LANE_W];
                    bus_dout_en = 2'b10;
                end else if (wide_q && area_wide) begin
                    bus_dout    = wdata_q;
                    bus_dout_en = 2'b11;
                end else if (use_low) begin
                    bus_dout[LANE_W-1:0] = wdata_q[LANE_W-1:0];
                    bus_dout_en = 2'b01;
                end else begin
                    bus_dout[DATA_W-1:LANE_W] = wdata_q[LANE_W-1:0];
                    bus_dout_en = 2'b10;
                end
            end
        end
        done  = done_q;
        rdata = rdata_q;
    end

endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int AREAS     = 8,
    parameter int ADDR_W    = 24,
    parameter int DATA_W    = 16,
    parameter int RST_WAITS = 7,
    localparam int AREA_BITS = $clog2(AREAS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [AREA_BITS-1:0] cfg_area,
    input  logic                 cfg_wide,
    input  logic                 cfg_three,
    input  logic [WAIT_W-1:0]    cfg_waits,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_wide,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [DATA_W-1:0]    req_wdata,
    output logic                 done,
    output logic [DATA_W-1:0]    rdata,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic [DATA_W-1:0]    bus_dout,
    output logic [1:0]           bus_dout_en,
    input  logic [DATA_W-1:0]    bus_din,
    output logic [AREAS-1:0]     cs_n,
    output logic                 rd_n,
    output logic                 wr_n,
    input  logic                 wait_n,
    output logic                 bus16_mode
);

    area_cfg_t [AREAS-1:0] cfg_tbl;
    area_cfg_t             sel_cfg;
    area_cfg_t             cur_cfg;
    logic accept, active, strobe_on, last, final_last, split, second;

    always_comb begin
        sel_cfg = cfg_tbl[req_addr[ADDR_W-1 -: AREA_BITS]];
    end

    bcs_cfg_bank #(
        .AREAS     (AREAS),
        .RST_WAITS (RST_WAITS)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_area  (cfg_area),
        .cfg_wide  (cfg_wide),
        .cfg_three (cfg_three),
        .cfg_waits (cfg_waits),
        .cfg_tbl   (cfg_tbl),
        .mode16    (bus16_mode)
    );

    bcs_seq_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_wide   (req_wide),
        .sel_cfg    (sel_cfg),
        .wait_n     (wait_n),
        .cur_cfg    (cur_cfg),
        .accept     (accept),
        .active     (active),
        .strobe_on  (strobe_on),
        .last       (last),
        .final_last (final_last),
        .split      (split),
        .second     (second)
    );

    bcs_datapath #(
        .AREAS  (AREAS),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept      (accept),
        .req_write   (req_write),
        .req_wide    (req_wide),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .area_wide   (cur_cfg.wide),
        .active      (active),
        .strobe_on   (strobe_on),
        .last        (last),
        .final_last  (final_last),
        .split       (split),
        .second      (second),
        .bus_din     (bus_din),
        .bus_addr    (bus_addr),
        .bus_dout    (bus_dout),
        .bus_dout_en (bus_dout_en),
        .cs_n        (cs_n),
        .rd_n        (rd_n),
        .wr_n        (wr_n),
        .done        (done),
        .rdata       (rdata)
    );

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int AREAS = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [AREAS-1:0] cs_n,
    input logic             rd_n,
    input logic             wr_n,
    input logic             done,
    input logic [1:0]       dout_en
);

    assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_strobe_in_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> (cs_n != '1));

    assert_first_state_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((cs_n != '1) && ($past(cs_n) == '1)) |-> (rd_n && wr_n));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n == '1));

    assert_lane_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_en != 2'b00) |-> ((cs_n != '1) && rd_n));

endmodule

bind bus_cycle_seq bcs_checker #(.AREAS(AREAS)) u_bcs_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cs_n    (cs_n),
    .rd_n    (rd_n),
    .wr_n    (wr_n),
    .done    (done),
    .dout_en (bus_dout_en)
);

// File: tb/tb_bus_cycle_seq.sv
`timescale 1ns/1ps
module tb_bus_cycle_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_area = '0;
    logic        cfg_wide = 1'b0;
    logic        cfg_three = 1'b0;
    logic [2:0]  cfg_waits = '0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        done;
    logic [15:0] rdata;
    logic [23:0] bus_addr;
    logic [15:0] bus_dout;
    logic [1:0]  bus_dout_en;
    logic [15:0] bus_din;
    logic [7:0]  cs_n;
    logic        rd_n, wr_n;
    logic        wait_n = 1'b1;
    logic        bus16_mode;

    int n_cmp = 0;
    int n_bad = 0;
    logic [7:0] area16 = '0;

    always #2.5 clk = ~clk;

    bus_cycle_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_area(cfg_area),
        .cfg_wide(cfg_wide), .cfg_three(cfg_three), .cfg_waits(cfg_waits),
        .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
        .req_addr(req_addr), .req_wdata(req_wdata), .done(done), .rdata(rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_dout_en(bus_dout_en),
        .bus_din(bus_din), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .wait_n(wait_n), .bus16_mode(bus16_mode)
    );

    function automatic logic [7:0] bmod(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction

    // External memory model: byte per address, lanes per area width.
    assign bus_din = area16[bus_addr[23:21]]
                   ? {bmod({bus_addr[23:1], 1'b0}), bmod({bus_addr[23:1], 1'b1})}
                   : {bmod(bus_addr), 8'hEE};

    // Per-access record
    int          r_cs, r_strb, r_half, r_done;
    logic        r_csbad, r_strbbad;
    logic [7:0]  r_csv;
    logic [15:0] r_rdata;
    logic [23:0] r_addr [2];
    logic [15:0] r_dout [2];
    logic [1:0]  r_en   [2];
    logic        pend_cfg = 1'b0;
    logic [2:0]  pend_area;
    logic [2:0]  pend_waits;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic set_area(input logic [2:0] a, input logic w, input logic t, input logic [2:0] n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_area = a; cfg_wide = w; cfg_three = t; cfg_waits = n;
        @(negedge clk);
        cfg_we = 1'b0;
        area16[a] = w;
    endtask

    task automatic run_acc(input logic wr, input logic wd, input logic [23:0] a,
                           input logic [15:0] wdv, input int w_at, input int w_len);
        int hc;
        int guard;
        r_cs = 0; r_strb = 0; r_half = 0; r_done = 0;
        r_csbad = 1'b0; r_strbbad = 1'b0; r_csv = '1; r_rdata = '0;
        for (int i = 0; i < 2; i++) begin
            r_addr[i] = '0; r_dout[i] = '0; r_en[i] = '0;
        end
        hc = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wide = wd; req_addr = a; req_wdata = wdv;
        wait_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (guard < 300) begin
            if (cs_n != '1) begin
                r_cs++;
                if (r_cs == 1) r_csv = cs_n;
                else if (cs_n != r_csv) r_csbad = 1'b1;
                if (rd_n && wr_n) begin
                    hc = 1;
                    r_half++;
                end else begin
                    hc++;
                    r_strb++;
                    if ((wr && !rd_n) || (!wr && !wr_n)) r_strbbad = 1'b1;
                    if (r_half >= 1 && r_half <= 2) begin
                        r_addr[r_half-1] = bus_addr;
                        r_dout[r_half-1] = bus_dout;
                        r_en[r_half-1]   = bus_dout_en;
                    end
                end
                wait_n = !(hc >= w_at && hc < w_at + w_len);
                if (pend_cfg && r_cs == 1) begin
                    cfg_we = 1'b1; cfg_area = pend_area; cfg_wide = 1'b0;
                    cfg_three = 1'b1; cfg_waits = pend_waits;
                end
                if (pend_cfg && r_cs == 2) begin
                    cfg_we = 1'b0; pend_cfg = 1'b0;
                end
            end
            if (done) begin
                r_done++;
                r_rdata = rdata;
                break;
            end
            @(negedge clk);
            guard++;
        end
        wait_n = 1'b1;
        if (r_done == 0) chk("R9 done never seen", 0, 1);
        repeat (2) begin
            @(negedge clk);
            if (done) r_done++;
        end
    endtask

    task automatic t_reset_state();
        chk("R10 cs_n idle", cs_n, 8'hFF);
        chk("R10 rd_n idle", rd_n, 1);
        chk("R10 wr_n idle", wr_n, 1);
        chk("R10 done idle", done, 0);
        chk("R2 bus16 after reset", bus16_mode, 0);
    endtask

    task automatic t_reset_timing();
        run_acc(1'b0, 1'b0, 24'h000012, 16'h0, 0, 0);
        chk("R10 R4 default length", r_cs, 10);
        chk("R6 strobe states", r_strb, 9);
        chk("R9 byte read data", r_rdata, {8'h00, bmod(24'h000012)});
        chk("R1 area0 select", r_csv, 8'hFE);
        chk("R1 cs steady", r_csbad, 0);
        chk("R9 single done", r_done, 1);
    endtask

    task automatic t_two_state();
        set_area(3'd1, 1'b1, 1'b0, 3'd5);
        @(negedge clk);
        chk("R2 bus16 one wide area", bus16_mode, 1);
        run_acc(1'b0, 1'b0, 24'h200031, 16'h0, 1, 100);
        chk("R3 two-state length", r_cs, 2);
        chk("R3 strobe states", r_strb, 1);
        chk("R7 odd byte lower lane read", r_rdata, {8'h00, bmod(24'h200031)});
        chk("R1 area1 select", r_csv, 8'hFD);
        chk("R6 read strobe only", r_strbbad, 0);
    endtask

    task automatic t_prog_waits();
        set_area(3'd2, 1'b0, 1'b1, 3'd0);
        run_acc(1'b0, 1'b0, 24'h400008, 16'h0, 0, 0);
        chk("R4 zero waits length", r_cs, 3);
        set_area(3'd2, 1'b0, 1'b1, 3'd3);
        run_acc(1'b0, 1'b0, 24'h400009, 16'h0, 0, 0);
        chk("R4 three waits length", r_cs, 6);
        chk("R8 8-bit odd byte upper lane", r_rdata, {8'h00, bmod(24'h400009)});
    endtask

    task automatic t_ext_wait();
        run_acc(1'b0, 1'b0, 24'h400010, 16'h0, 5, 2);
        chk("R5 two low samples after waits", r_cs, 8);
        run_acc(1'b0, 1'b0, 24'h400011, 16'h0, 2, 2);
        chk("R5 low before sample point ignored", r_cs, 6);
        set_area(3'd2, 1'b0, 1'b1, 3'd0);
        run_acc(1'b0, 1'b0, 24'h400012, 16'h0, 2, 3);
        chk("R5 zero waits pin sampled in T2", r_cs, 6);
    endtask

    task automatic t_lanes_16();
        run_acc(1'b1, 1'b0, 24'h200040, 16'h77A5, 0, 0);
        chk("R7 even byte write enable", r_en[0], 2'b10);
        chk("R7 even byte write data", r_dout[0], 16'hA500);
        chk("R6 write strobe only", r_strbbad, 0);
        run_acc(1'b1, 1'b0, 24'h200041, 16'h77A5, 0, 0);
        chk("R7 odd byte write enable", r_en[0], 2'b01);
        chk("R7 odd byte write data", r_dout[0], 16'h00A5);
        run_acc(1'b1, 1'b1, 24'h200051, 16'h1234, 0, 0);
        chk("R7 word write enable", r_en[0], 2'b11);
        chk("R7 word write data", r_dout[0], 16'h1234);
        chk("R7 word address even", r_addr[0], 24'h200050);
        run_acc(1'b0, 1'b1, 24'h200060, 16'h0, 0, 0);
        chk("R7 word read data", r_rdata, {bmod(24'h200060), bmod(24'h200061)});
        chk("R7 word read one cycle", r_cs, 2);
    endtask

    task automatic t_split();
        set_area(3'd3, 1'b0, 1'b1, 3'd1);
        run_acc(1'b0, 1'b1, 24'h600020, 16'h0, 0, 0);
        chk("R8 split length", r_cs, 8);
        chk("R8 two byte cycles", r_half, 2);
        chk("R8 first address even", r_addr[0], 24'h600020);
        chk("R8 second address odd", r_addr[1], 24'h600021);
        chk("R8 assembled data", r_rdata, {bmod(24'h600020), bmod(24'h600021)});
        chk("R8 single done", r_done, 1);
        run_acc(1'b1, 1'b1, 24'h600030, 16'hBEEF, 0, 0);
        chk("R8 write first half data", r_dout[0], 16'hBE00);
        chk("R8 write second half data", r_dout[1], 16'hEF00);
        chk("R8 write upper lane only", {r_en[0], r_en[1]}, 4'b1010);
    endtask

    task automatic t_latch();
        set_area(3'd4, 1'b0, 1'b1, 3'd2);
        pend_cfg = 1'b1; pend_area = 3'd4; pend_waits = 3'd7;
        run_acc(1'b0, 1'b0, 24'h800002, 16'h0, 0, 0);
        chk("R11 captured settings kept", r_cs, 5);
        run_acc(1'b0, 1'b0, 24'h800003, 16'h0, 0, 0);
        chk("R11 new settings used", r_cs, 10);
    endtask

    task automatic t_mode_back();
        set_area(3'd1, 1'b0, 1'b1, 3'd0);
        @(negedge clk);
        chk("R2 bus16 all 8-bit", bus16_mode, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_reset_timing();
        t_two_state();
        t_prog_waits();
        t_ext_wait();
        t_lanes_16();
        t_split();
        t_latch();
        t_mode_back();
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule